// File: doc/BRIEF.md
# Operand-Capturing Reservation Station Pool

This block is a pool of reservation stations that sits in front of a single functional unit. An in-order issue port places each instruction into a free station. Each of its two source operands arrives either as a value or as the tag of the instruction that will produce it. Each station receives the tag that names its own future result, and the issue side gets that tag back on the same cycle, so it can rename the destination register.

Stations that still wait for an operand watch a broadcast result bus, which carries a tag and a value. A station takes the value whenever the tag on the bus matches the tag it is waiting for. Once a station holds both operands it competes for the functional unit. The oldest ready station wins, and it hands over its opcode, its two operand values and its result tag. The station then frees itself. Dispatch therefore follows operand readiness and not program order.

Top module: `rs_pool`

## Requirements
- R1: After reset all stations are free, `iss_ready_o` is 1 and `fu_valid_o` is 0.
- R2: An instruction is accepted on a cycle where `iss_valid_i` and `iss_ready_o` are both 1. It goes into the lowest-numbered free station k, and `iss_tag_o` shows that station's result tag, TAG_BASE + k, on the same cycle (TAG_BASE = 1 by default).
- R3: While all NUM_RS stations are occupied, `iss_ready_o` is 0.
- R4: An operand issued with its ready flag at 1 is delivered unchanged to `fu_a_o` or `fu_b_o`, and the opcode is delivered unchanged to `fu_op_o`.
- R5: A waiting operand captures `cdb_val_i` only on a cycle where `cdb_valid_i` is 1 and `cdb_tag_i` equals its tag. A bus word with another tag, or with `cdb_valid_i` at 0, leaves it waiting.
- R6: An operand issued as waiting captures a matching bus word that appears on the issue cycle itself.
- R7: A station is offered to the unit only when both operands hold values. `fu_valid_o` rises on the cycle after the last capture, and it stays 0 while every station is free or waiting.
- R8: Among ready stations, the one issued earliest is offered first, including after freed stations have been reused.
- R9: At most one station dispatches per cycle, and only on a cycle where `fu_ready_i` is 1. While `fu_ready_i` is 0 the offer stays valid.
- R10: A station that dispatches is free on the next cycle: `iss_ready_o` returns to 1 and the station's tag can be handed out again.
- R11: `fu_tag_o` carries the result tag of the station being offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | A station is free |
| iss_op_i | input | OP_W | Opcode of issued instruction |
| iss_a_rdy_i | input | 1 | Operand A is a value (1) or a tag (0) |
| iss_a_tag_i | input | TAG_W | Producer tag of operand A |
| iss_a_val_i | input | DATA_W | Value of operand A |
| iss_b_rdy_i | input | 1 | Operand B is a value (1) or a tag (0) |
| iss_b_tag_i | input | TAG_W | Producer tag of operand B |
| iss_b_val_i | input | DATA_W | Value of operand B |
| iss_tag_o | output | TAG_W | Result tag assigned to the issuing instruction |
| cdb_valid_i | input | 1 | Result bus carries a result |
| cdb_tag_i | input | TAG_W | Result bus tag |
| cdb_val_i | input | DATA_W | Result bus value |
| fu_ready_i | input | 1 | Functional unit accepts an instruction |
| fu_valid_o | output | 1 | A ready station is offered |
| fu_op_o | output | OP_W | Opcode to unit |
| fu_a_o | output | DATA_W | Operand A to unit |
| fu_b_o | output | DATA_W | Operand B to unit |
| fu_tag_o | output | TAG_W | Result tag to unit |

## Verification
The hardest case to reach is an oldest-first choice that differs from both station index order and issue order of readiness. It needs an older station that becomes ready after a younger one, and a freed low-index station that is reused behind higher-index ones. The stimulus holds `fu_ready_i` low to fill the pool, releases one dispatch at a time, and wakes a waiting older station with a bus word while younger stations are already ready. A sweep of every bus tag against a waiting station shows that only the matching tag, with the valid bit set, wakes it.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    SRC_PEND  = 1'b0,
    SRC_VALUE = 1'b1
  } src_state_e;

  localparam int unsigned SRC_CNT = 2;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned OP_W   = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            alloc_i,
  input  logic [OP_W-1:0]                 op_i,
  input  logic [SRC_CNT-1:0]              src_rdy_i,
  input  logic [SRC_CNT-1:0][TAG_W-1:0]   src_tag_i,
  input  logic [SRC_CNT-1:0][DATA_W-1:0]  src_val_i,
  input  logic                            cdb_valid_i,
  input  logic [TAG_W-1:0]                cdb_tag_i,
  input  logic [DATA_W-1:0]               cdb_val_i,
  input  logic                            release_i,
  output logic                            busy_o,
  output logic                            ready_o,
  output logic [OP_W-1:0]                 op_o,
  output logic [SRC_CNT-1:0][DATA_W-1:0]  src_o
);
  logic                busy_q;
  logic [OP_W-1:0]     op_q;
  logic [SRC_CNT-1:0]  have;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
    end else if (release_i) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < SRC_CNT; k++) begin : g_src
    src_state_e        st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic              new_hit, old_hit;

    assign new_hit = cdb_valid_i && (cdb_tag_i == src_tag_i[k]);
    assign old_hit = busy_q && (st_q == SRC_PEND) && cdb_valid_i && (cdb_tag_i == tag_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= SRC_PEND;
        tag_q <= '0;
        val_q <= '0;
      end else if (alloc_i) begin
        tag_q <= src_tag_i[k];
        if (src_rdy_i[k]) begin
          st_q  <= SRC_VALUE;
          val_q <= src_val_i[k];
        end else if (new_hit) begin
          // bypass: producer broadcasts on the issue cycle
          st_q  <= SRC_VALUE;
          val_q <= cdb_val_i;
        end else begin
          st_q  <= SRC_PEND;
        end
      end else if (old_hit) begin
        st_q  <= SRC_VALUE;
        val_q <= cdb_val_i;
      end
    end

    assign have[k]  = (st_q == SRC_VALUE);
    assign src_o[k] = val_q;
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && (&have);
  assign op_o    = op_q;
endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
  parameter int unsigned NUM_RS = 3,
  localparam int unsigned IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic [NUM_RS-1:0] busy_i,
  output logic              any_o,
  output logic [NUM_RS-1:0] pick_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    pick_o = '0;
    idx_o  = '0;
    for (int i = NUM_RS - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        pick_o    = '0;
        pick_o[i] = 1'b1;
        idx_o     = IDX_W'(i);
      end
    end
  end

  assign any_o = ~&busy_i;
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int unsigned NUM_RS = 3,
  localparam int unsigned IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_RS-1:0] alloc_i,
  input  logic [NUM_RS-1:0] busy_i,
  input  logic [NUM_RS-1:0] ready_i,
  output logic [NUM_RS-1:0] grant_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  // older_q[i][j]: station i was issued before station j
  logic [NUM_RS-1:0][NUM_RS-1:0] older_q;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_row
    for (genvar j = 0; j < NUM_RS; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older_q[i][j] = 1'b0;
      end else begin : g_cell
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)         older_q[i][j] <= 1'b0;
          else if (alloc_i[j]) older_q[i][j] <= busy_i[i];
          else if (alloc_i[i]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_RS; i++) begin : g_gnt
    logic [NUM_RS-1:0] blockers;
    for (genvar j = 0; j < NUM_RS; j++) begin : g_blk
      assign blockers[j] = ready_i[j] && older_q[j][i];
    end
    assign grant_o[i] = ready_i[i] && !(|blockers);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (grant_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |ready_i;
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int unsigned NUM_RS   = 3,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned OP_W     = 3,
  parameter int unsigned TAG_BASE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  output logic              iss_ready_o,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic              iss_a_rdy_i,
  input  logic [TAG_W-1:0]  iss_a_tag_i,
  input  logic [DATA_W-1:0] iss_a_val_i,
  input  logic              iss_b_rdy_i,
  input  logic [TAG_W-1:0]  iss_b_tag_i,
  input  logic [DATA_W-1:0] iss_b_val_i,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  input  logic              fu_ready_i,
  output logic              fu_valid_o,
  output logic [OP_W-1:0]   fu_op_o,
  output logic [DATA_W-1:0] fu_a_o,
  output logic [DATA_W-1:0] fu_b_o,
  output logic [TAG_W-1:0]  fu_tag_o
);
  localparam int unsigned IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;
  localparam logic [TAG_W-1:0] BASE = TAG_W'(TAG_BASE);

  logic [NUM_RS-1:0] busy, ready, free_pick, alloc, grant, rel;
  logic [IDX_W-1:0]  free_idx, gnt_idx;
  logic              free_any, gnt_any;

  logic [SRC_CNT-1:0]             src_rdy;
  logic [SRC_CNT-1:0][TAG_W-1:0]  src_tag;
  logic [SRC_CNT-1:0][DATA_W-1:0] src_val;

  logic [NUM_RS-1:0][OP_W-1:0]                 ent_op;
  logic [NUM_RS-1:0][SRC_CNT-1:0][DATA_W-1:0]  ent_src;

  assign src_rdy = {iss_b_rdy_i, iss_a_rdy_i};
  assign src_tag = {iss_b_tag_i, iss_a_tag_i};
  assign src_val = {iss_b_val_i, iss_a_val_i};

  rs_free_pick #(.NUM_RS(NUM_RS)) u_free (
    .busy_i (busy),
    .any_o  (free_any),
    .pick_o (free_pick),
    .idx_o  (free_idx)
  );

  assign iss_ready_o = free_any;
  assign iss_tag_o   = BASE + TAG_W'(free_idx);
  assign alloc       = (iss_valid_i && free_any) ? free_pick : '0;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_ent
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[i]),
      .op_i        (iss_op_i),
      .src_rdy_i   (src_rdy),
      .src_tag_i   (src_tag),
      .src_val_i   (src_val),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_val_i   (cdb_val_i),
      .release_i   (rel[i]),
      .busy_o      (busy[i]),
      .ready_o     (ready[i]),
      .op_o        (ent_op[i]),
      .src_o       (ent_src[i])
    );
  end

  rs_age_pick #(.NUM_RS(NUM_RS)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc),
    .busy_i  (busy),
    .ready_i (ready),
    .grant_o (grant),
    .idx_o   (gnt_idx),
    .any_o   (gnt_any)
  );

  assign rel        = fu_ready_i ? grant : '0;
  assign fu_valid_o = gnt_any;
  assign fu_op_o    = ent_op[gnt_idx];
  assign fu_a_o     = ent_src[gnt_idx][0];
  assign fu_b_o     = ent_src[gnt_idx][1];
  assign fu_tag_o   = BASE + TAG_W'(gnt_idx);
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int unsigned NUM_RS   = 3,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned TAG_BASE = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iss_valid_i,
  input logic             iss_ready_o,
  input logic             fu_valid_o,
  input logic             fu_ready_i,
  input logic [TAG_W-1:0] fu_tag_o
);
  localparam int unsigned OCC_W = $clog2(NUM_RS + 1) + 1;

  logic [OCC_W-1:0] occ_q;
  logic             put, take;

  assign put  = iss_valid_i && iss_ready_o;
  assign take = fu_valid_o && fu_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + OCC_W'(put) - OCC_W'(take);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_q) <= NUM_RS); // R2

  AST_STALL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(occ_q) == NUM_RS) |-> !iss_ready_o); // R3

  AST_ACCEPT_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(occ_q) < NUM_RS) |-> iss_ready_o); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0) |-> !fu_valid_o); // R7

  AST_OFFER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fu_valid_o && !fu_ready_i) |=> fu_valid_o); // R9

  AST_REUSE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> iss_ready_o); // R10

  AST_TAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fu_valid_o |-> (int'(fu_tag_o) >= TAG_BASE && int'(fu_tag_o) < TAG_BASE + NUM_RS)); // R11
endmodule

bind rs_pool rs_pool_chk #(.NUM_RS(NUM_RS), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_ready_o (iss_ready_o),
  .fu_valid_o  (fu_valid_o),
  .fu_ready_i  (fu_ready_i),
  .fu_tag_o    (fu_tag_o)
);

// File: tb/rs_pool_test.sv
`timescale 1ns/1ps
module rs_pool_test;
  localparam int DW = 16, TW = 4, OW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          iss_valid_i = 1'b0;
  logic          iss_ready_o;
  logic [OW-1:0] iss_op_i = '0;
  logic          iss_a_rdy_i = 1'b0;
  logic [TW-1:0] iss_a_tag_i = '0;
  logic [DW-1:0] iss_a_val_i = '0;
  logic          iss_b_rdy_i = 1'b0;
  logic [TW-1:0] iss_b_tag_i = '0;
  logic [DW-1:0] iss_b_val_i = '0;
  logic [TW-1:0] iss_tag_o;
  logic          cdb_valid_i = 1'b0;
  logic [TW-1:0] cdb_tag_i = '0;
  logic [DW-1:0] cdb_val_i = '0;
  logic          fu_ready_i = 1'b0;
  logic          fu_valid_o;
  logic [OW-1:0] fu_op_o;
  logic [DW-1:0] fu_a_o, fu_b_o;
  logic [TW-1:0] fu_tag_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  rs_pool uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    iss_valid_i = 1'b0;
    cdb_valid_i = 1'b0;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; iss_valid_i = 1'b0; cdb_valid_i = 1'b0; fu_ready_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic issue(logic [OW-1:0] op, logic ar, logic [TW-1:0] at, logic [DW-1:0] av,
                       logic br, logic [TW-1:0] bt, logic [DW-1:0] bv);
    iss_valid_i = 1'b1; iss_op_i = op;
    iss_a_rdy_i = ar; iss_a_tag_i = at; iss_a_val_i = av;
    iss_b_rdy_i = br; iss_b_tag_i = bt; iss_b_val_i = bv;
  endtask

  task automatic bus(logic [TW-1:0] t, logic [DW-1:0] v);
    cdb_valid_i = 1'b1; cdb_tag_i = t; cdb_val_i = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL R1 watchdog act=hang exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    do_reset(); settle();
    chk("R1 iss_ready", iss_ready_o, 1);
    chk("R1 fu_valid", fu_valid_o, 0);

    // fill, stall, bypass capture, reuse, oldest-first wake
    issue(1, 1, 0, 5, 1, 0, 7); settle();
    chk("R2 tag st0", iss_tag_o, 1);
    tick(); settle();
    chk("R7 valid", fu_valid_o, 1);
    chk("R11 tag", fu_tag_o, 1);
    chk("R4 a", fu_a_o, 5);
    chk("R4 b", fu_b_o, 7);
    chk("R4 op", fu_op_o, 1);
    issue(2, 0, 9, 0, 1, 0, 3); settle();
    chk("R2 tag st1", iss_tag_o, 2);
    tick();
    issue(3, 1, 0, 4, 0, 10, 0); bus(10, 99); settle();
    chk("R2 tag st2", iss_tag_o, 3);
    tick(); settle();
    chk("R3 full", iss_ready_o, 0);
    chk("R9 held", fu_valid_o, 1);
    chk("R9 held tag", fu_tag_o, 1);
    fu_ready_i = 1'b1; tick(); settle();
    chk("R6 bypass tag", fu_tag_o, 3);
    chk("R6 bypass b", fu_b_o, 99);
    chk("R4 a st2", fu_a_o, 4);
    chk("R10 free", iss_ready_o, 1);
    fu_ready_i = 1'b0;
    issue(5, 1, 0, 11, 1, 0, 12); settle();
    chk("R10 reuse tag", iss_tag_o, 1);
    tick(); settle();
    chk("R8 older first", fu_tag_o, 3);
    bus(9, 77); tick(); settle();
    chk("R8 woken oldest", fu_tag_o, 2);
    chk("R5 capture a", fu_a_o, 77);
    chk("R4 b st1", fu_b_o, 3);
    fu_ready_i = 1'b1; tick(); settle();
    chk("R9 one per cycle", fu_tag_o, 3);
    tick(); settle();
    chk("R8 youngest last", fu_tag_o, 1);
    chk("R4 a reuse", fu_a_o, 11);
    tick(); settle();
    chk("R7 drained", fu_valid_o, 0);

    // bus tag sweep against a station waiting on tag 9 for both operands
    do_reset();
    issue(6, 0, 9, 0, 0, 9, 0); tick();
    for (int t = 0; t < 16; t++) begin
      if (t != 9) begin
        bus(TW'(t), DW'(100 + t)); tick(); settle();
        chk("R5 mismatch ignored", fu_valid_o, 0);
      end
    end
    cdb_tag_i = 9; cdb_val_i = 16'h5555; cdb_valid_i = 1'b0; tick(); settle();
    chk("R5 invalid ignored", fu_valid_o, 0);
    bus(9, 16'h1234); tick(); settle();
    chk("R7 both captured", fu_valid_o, 1);
    chk("R5 a value", fu_a_o, 16'h1234);
    chk("R5 b value", fu_b_o, 16'h1234);
    chk("R4 op", fu_op_o, 6);

    // age order survives reuse of a low-index station
    do_reset();
    for (int i = 0; i < 3; i++) begin
      issue(OW'(i), 1, 0, DW'(21 + i), 1, 0, DW'(i)); tick();
    end
    settle();
    chk("R3 full again", iss_ready_o, 0);
    fu_ready_i = 1'b1; settle();
    chk("R8 first", fu_tag_o, 1);
    tick(); fu_ready_i = 1'b0;
    issue(7, 1, 0, 24, 1, 0, 0); settle();
    chk("R10 reuse st0", iss_tag_o, 1);
    tick(); fu_ready_i = 1'b1; settle();
    chk("R8 st1 before reused st0", fu_tag_o, 2);
    chk("R4 a st1", fu_a_o, 22);
    tick(); settle();
    chk("R8 st2 next", fu_tag_o, 3);
    chk("R4 a st2", fu_a_o, 23);
    tick(); settle();
    chk("R8 reused last", fu_tag_o, 1);
    chk("R4 a reused", fu_a_o, 24);
    tick(); settle();
    chk("R7 empty", fu_valid_o, 0);
    chk("R10 all free", iss_ready_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule